// File: doc/BRIEF.md
# Calendar Alarm Comparator with Interrupt Pin

This block watches the current seconds, minutes, hours and day-of-month, all given in BCD, and compares them with four programmed alarm bytes. Each alarm byte carries an exclusion bit, so any field can be left out of the comparison. When every included field is equal on a once-per-second update strobe, an alarm flag is latched. A watchdog event and a power-fail event latch their own flags in the same status byte.

A single interrupt pin is driven from the flags whose enable bits are set in a control byte. The same control byte sets the pin's polarity and chooses between two modes. In level mode the pin holds until the host reads the status byte. In pulse mode the pin asserts for a fixed, parameterised number of clock cycles on each enabled event.

Reading the status byte clears all flags. The time-of-day counter is outside this block. It only supplies the time fields and the update strobe.

Top module: `rtc_alarm_irq`

## Requirements
- R1: After reset the status byte reads 0x00, the control byte is 0 and the interrupt pin is high (idle, active-low, level mode, all sources off).
- R2: Alarm bytes are written at addresses 0 (seconds), 1 (minutes), 2 (hours) and 3 (date). When `tick_i` is high and every included field has alarm bits 6:0 equal to the time field, status bit 0 reads 1 from the next cycle on.
- R3: Bit 7 of an alarm byte set to 1 removes that field from the comparison. Set to 0, the field takes part.
- R4: With bit 7 set in all four alarm bytes, every `tick_i` sets the alarm flag.
- R5: Equal fields without `tick_i` never set the alarm flag.
- R6: A `wdog_evt_i` pulse sets status bit 1 and a `pfail_evt_i` pulse sets status bit 2. Status bits 7:3 always read 0.
- R7: A cycle with `flags_rd_i` high clears the status byte for the next cycle. An event in that same cycle still leaves its own flag set.
- R8: The control byte is at address 4. Bit 0 enables the alarm source, bit 1 the watchdog source and bit 2 the power-fail source. A source whose enable bit is 0 never moves the pin.
- R9: In level mode (control bit 4 = 0) the pin is active from the cycle after an enabled flag is set until the cycle after the status read that clears it.
- R10: In pulse mode (control bit 4 = 1) the pin is active for exactly PULSE_CYCLES cycles, starting the cycle after an enabled event. The pin then goes idle while the flag stays set.
- R11: Control bit 3 = 1 makes the pin active-high. When it is 0 the pin is active-low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle strobe when the time fields have just advanced |
| sec_i | input | 7 | Current seconds, BCD |
| min_i | input | 7 | Current minutes, BCD |
| hour_i | input | 7 | Current hours, BCD |
| date_i | input | 7 | Current day of month, BCD |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register address (0..3 alarm, 4 control) |
| wr_data_i | input | 8 | Register write data |
| flags_rd_i | input | 1 | Status byte read strobe; clears the flags |
| wdog_evt_i | input | 1 | Watchdog expiry pulse |
| pfail_evt_i | input | 1 | Power-fail detect pulse |
| flags_o | output | 8 | Status byte: bit 0 alarm, bit 1 watchdog, bit 2 power-fail |
| irq_o | output | 1 | Interrupt pin |

## Verification
A status read and a new event can land in the same clock cycle. This can lose an interrupt if the clear wins. The bench latches the watchdog flag first. It then raises the read strobe in the same cycle as a power-fail pulse. The expected result is a status byte of 0x04 on the following cycle: the old flag is cleared and the new one survives.

// File: rtl/rtc_alarm_pkg.sv
package rtc_alarm_pkg;

    // Interrupt control byte, bit 0 at the bottom
    typedef struct packed {
        logic pulse_mode;   // bit 4
        logic act_high;     // bit 3
        logic pf_en;        // bit 2
        logic wd_en;        // bit 1
        logic al_en;        // bit 0
    } irq_ctrl_t;

    // Latched event flags, bit 0 at the bottom
    typedef struct packed {
        logic pf;           // bit 2
        logic wd;           // bit 1
        logic al;           // bit 0
    } flags_t;

    localparam int CTRL_W  = $bits(irq_ctrl_t);
    localparam int FLAGS_W = $bits(flags_t);

endpackage

// File: rtl/rtc_alarm_cmp.sv
module rtc_alarm_cmp #(
    parameter int FIELDS = 4,
    parameter int FW     = 8
) (
    input  logic [FIELDS-1:0][FW-1:0] alarm_i,
    input  logic [FIELDS-1:0][FW-2:0] time_i,
    output logic                      match_o
);
    logic [FIELDS-1:0] hit;

    for (genvar g = 0; g < FIELDS; g++) begin : g_field
        // MSB of an alarm byte excludes the field from the compare
        assign hit[g] = alarm_i[g][FW-1] | (alarm_i[g][FW-2:0] == time_i[g]);
    end

    assign match_o = &hit;
endmodule

// File: rtl/rtc_alarm_regs.sv
module rtc_alarm_regs
    import rtc_alarm_pkg::*;
#(
    parameter int FIELDS    = 4,
    parameter int FW        = 8,
    parameter int AW        = 3,
    parameter int CTRL_ADDR = 4
) (
    input  logic                      clk_i,
    input  logic                      rst_ni,
    input  logic                      wr_en_i,
    input  logic [AW-1:0]             wr_addr_i,
    input  logic [FW-1:0]             wr_data_i,
    output logic [FIELDS-1:0][FW-1:0] alarm_o,
    output irq_ctrl_t                 ctrl_o
);
    typedef struct packed {
        logic [FIELDS-1:0][FW-1:0] alarm;
        irq_ctrl_t                 ctrl;
    } regs_t;

    regs_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en_i) begin
            for (int i = 0; i < FIELDS; i++) begin
                if (wr_addr_i == AW'(i)) st_d.alarm[i] = wr_data_i;
            end
            if (wr_addr_i == AW'(CTRL_ADDR)) st_d.ctrl = irq_ctrl_t'(wr_data_i[CTRL_W-1:0]);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign alarm_o = st_q.alarm;
    assign ctrl_o  = st_q.ctrl;
endmodule

// File: rtl/rtc_irq_drive.sv
module rtc_irq_drive
    import rtc_alarm_pkg::*;
#(
    parameter int PULSE_CYCLES = 4
) (
    input  logic      clk_i,
    input  logic      rst_ni,
    input  irq_ctrl_t ctrl_i,
    input  flags_t    flags_i,
    input  logic      trig_i,
    output logic      irq_o
);
    localparam int CW = $clog2(PULSE_CYCLES + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } drv_t;

    drv_t st_d, st_q;
    logic level, active;

    always_comb begin
        st_d = st_q;
        if (!ctrl_i.pulse_mode)  st_d.cnt = '0;
        else if (trig_i)         st_d.cnt = CW'(PULSE_CYCLES);
        else if (st_q.cnt != '0) st_d.cnt = st_q.cnt - 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    always_comb begin
        level  = (flags_i.al & ctrl_i.al_en) |
                 (flags_i.wd & ctrl_i.wd_en) |
                 (flags_i.pf & ctrl_i.pf_en);
        active = ctrl_i.pulse_mode ? (st_q.cnt != '0) : level;
        irq_o  = ctrl_i.act_high ? active : ~active;
    end
endmodule

// File: rtl/rtc_alarm_irq.sv
module rtc_alarm_irq
    import rtc_alarm_pkg::*;
#(
    parameter int PULSE_CYCLES = 4,
    parameter int TW           = 7,
    parameter int AW           = 3
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          tick_i,
    input  logic [TW-1:0] sec_i,
    input  logic [TW-1:0] min_i,
    input  logic [TW-1:0] hour_i,
    input  logic [TW-1:0] date_i,
    input  logic          wr_en_i,
    input  logic [AW-1:0] wr_addr_i,
    input  logic [TW:0]   wr_data_i,
    input  logic          flags_rd_i,
    input  logic          wdog_evt_i,
    input  logic          pfail_evt_i,
    output logic [TW:0]   flags_o,
    output logic          irq_o
);
    localparam int FIELDS = 4;
    localparam int FW     = TW + 1;

    typedef struct packed {
        flags_t flags;
    } top_t;

    logic [FIELDS-1:0][FW-1:0] alarm;
    logic [FIELDS-1:0][TW-1:0] now;
    irq_ctrl_t                 ctrl;
    logic                      match, al_set, trig;
    top_t                      st_d, st_q;

    assign now = {date_i, hour_i, min_i, sec_i};

    rtc_alarm_regs #(
        .FIELDS(FIELDS), .FW(FW), .AW(AW), .CTRL_ADDR(FIELDS)
    ) u_regs (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .wr_en_i  (wr_en_i),
        .wr_addr_i(wr_addr_i),
        .wr_data_i(wr_data_i),
        .alarm_o  (alarm),
        .ctrl_o   (ctrl)
    );

    rtc_alarm_cmp #(.FIELDS(FIELDS), .FW(FW)) u_cmp (
        .alarm_i(alarm),
        .time_i (now),
        .match_o(match)
    );

    always_comb begin
        al_set = tick_i & match;
        trig   = (al_set & ctrl.al_en) | (wdog_evt_i & ctrl.wd_en) | (pfail_evt_i & ctrl.pf_en);
        st_d   = st_q;
        if (flags_rd_i) st_d.flags = '0;
        // a fresh event beats the clear of the same cycle
        st_d.flags.al = st_d.flags.al | al_set;
        st_d.flags.wd = st_d.flags.wd | wdog_evt_i;
        st_d.flags.pf = st_d.flags.pf | pfail_evt_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    rtc_irq_drive #(.PULSE_CYCLES(PULSE_CYCLES)) u_drv (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .ctrl_i (ctrl),
        .flags_i(st_q.flags),
        .trig_i (trig),
        .irq_o  (irq_o)
    );

    assign flags_o = {{(FW - FLAGS_W){1'b0}}, st_q.flags};
endmodule

// File: rtl/rtc_alarm_chk.sv
module rtc_alarm_chk
    import rtc_alarm_pkg::*;
(
    input logic       clk_i,
    input logic       rst_ni,
    input logic       tick_i,
    input logic       wr_en_i,
    input logic       flags_rd_i,
    input logic       wdog_evt_i,
    input logic       pfail_evt_i,
    input logic [7:0] flags_o,
    input logic       irq_o,
    input irq_ctrl_t  ctrl_i
);
    // R2 / R5: the alarm flag only rises after an update strobe
    a_r5_alarm_needs_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(flags_o[0]) |-> $past(tick_i));

    // R7: a quiet read leaves an empty status byte
    a_r7_read_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (flags_rd_i && !tick_i && !wdog_evt_i && !pfail_evt_i) |=> (flags_o == 8'h00));

    // R6 / R7: a watchdog event is never lost, even against a read
    a_r7_event_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wdog_evt_i |=> flags_o[1]);

    // R9: level mode holds the pin active while an enabled flag is set
    a_r9_level_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!ctrl_i.pulse_mode && ctrl_i.wd_en && flags_o[1]) |-> (irq_o == ctrl_i.act_high));

    // R10: pulse mode asserts the pin the cycle after an enabled event
    a_r10_pulse_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ctrl_i.pulse_mode && ctrl_i.wd_en && wdog_evt_i && !wr_en_i) |=> (irq_o == ctrl_i.act_high));

    // R11: with no flag in level mode the pin sits at its idle level
    a_r11_idle_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!ctrl_i.pulse_mode && flags_o[2:0] == 3'b000) |-> (irq_o == !ctrl_i.act_high));
endmodule

bind rtc_alarm_irq rtc_alarm_chk u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick_i),
    .wr_en_i    (wr_en_i),
    .flags_rd_i (flags_rd_i),
    .wdog_evt_i (wdog_evt_i),
    .pfail_evt_i(pfail_evt_i),
    .flags_o    (flags_o),
    .irq_o      (irq_o),
    .ctrl_i     (ctrl)
);

// File: tb/sim_rtc_alarm_irq.sv
`timescale 1ns/1ps
module sim_rtc_alarm_irq;
    localparam int PULSE = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic [6:0] sec = '0, mnt = '0, hr = '0, dt = '0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       rd = 1'b0, wdog = 1'b0, pfail = 1'b0;
    logic [7:0] flags;
    logic       irq;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    rtc_alarm_irq #(.PULSE_CYCLES(PULSE)) u0 (
        .clk_i(clk), .rst_ni(rst_n), .tick_i(tick),
        .sec_i(sec), .min_i(mnt), .hour_i(hr), .date_i(dt),
        .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
        .flags_rd_i(rd), .wdog_evt_i(wdog), .pfail_evt_i(pfail),
        .flags_o(flags), .irq_o(irq)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        step();
        wr_en = 1'b0;
    endtask

    task automatic rd_flags();
        rd = 1'b1;
        step();
        rd = 1'b0;
    endtask

    task automatic set_time(input logic [6:0] s, m, h, d);
        sec = s; mnt = m; hr = h; dt = d;
    endtask

    task automatic do_tick();
        tick = 1'b1;
        step();
        tick = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 status", flags, 8'h00);
        check("R1 pin", {7'd0, irq}, 8'h01);
    endtask

    task automatic t_match_basic();
        wr(3'd0, 8'h30); wr(3'd1, 8'h15); wr(3'd2, 8'h08); wr(3'd3, 8'h12);
        set_time(7'h30, 7'h15, 7'h08, 7'h12);
        do_tick();
        check("R2 match sets flag", flags, 8'h01);
        rd_flags();
        check("R7 read clears", flags, 8'h00);
        set_time(7'h31, 7'h15, 7'h08, 7'h12);
        do_tick();
        check("R2 mismatch", flags, 8'h00);
    endtask

    task automatic t_mask();
        wr(3'd0, 8'hB0);
        set_time(7'h45, 7'h15, 7'h08, 7'h12);
        do_tick();
        check("R3 excluded field", flags, 8'h01);
        rd_flags();
        set_time(7'h45, 7'h16, 7'h08, 7'h12);
        do_tick();
        check("R3 included field differs", flags, 8'h00);
    endtask

    task automatic t_all_masked();
        wr(3'd0, 8'h80); wr(3'd1, 8'h80); wr(3'd2, 8'h80); wr(3'd3, 8'h80);
        for (int i = 0; i < 2; i++) begin
            set_time(7'(i * 3), 7'h59, 7'h23, 7'h31);
            do_tick();
            check("R4 every tick", flags, 8'h01);
            rd_flags();
        end
    endtask

    task automatic t_no_tick();
        wr(3'd0, 8'h80);
        for (int i = 0; i < 4; i++) step();
        check("R5 no tick no flag", flags, 8'h00);
    endtask

    task automatic t_events();
        wdog = 1'b1; step(); wdog = 1'b0;
        check("R6 watchdog flag", flags, 8'h02);
        pfail = 1'b1; step(); pfail = 1'b0;
        check("R6 power-fail flag", flags, 8'h06);
        rd_flags();
        check("R7 read clears events", flags, 8'h00);
    endtask

    task automatic t_read_race();
        wdog = 1'b1; step(); wdog = 1'b0;
        rd = 1'b1; pfail = 1'b1;
        step();
        rd = 1'b0; pfail = 1'b0;
        check("R7 event beats read", flags, 8'h04);
        rd_flags();
    endtask

    task automatic t_disabled();
        wr(3'd4, 8'h00);
        wdog = 1'b1; step(); wdog = 1'b0;
        check("R8 disabled source pin idle", {7'd0, irq}, 8'h01);
        rd_flags();
    endtask

    task automatic t_level();
        wr(3'd4, 8'h02);
        pfail = 1'b1; step(); pfail = 1'b0;
        check("R8 pf disabled pin idle", {7'd0, irq}, 8'h01);
        rd_flags();
        wdog = 1'b1; step(); wdog = 1'b0;
        check("R9 level active", {7'd0, irq}, 8'h00);
        for (int i = 0; i < 3; i++) step();
        check("R9 level held", {7'd0, irq}, 8'h00);
        rd_flags();
        check("R9 level released by read", {7'd0, irq}, 8'h01);
    endtask

    task automatic t_pulse();
        int act = 0;
        wr(3'd4, 8'h12);
        wdog = 1'b1; step(); wdog = 1'b0;
        for (int i = 0; i < 2 * PULSE + 2; i++) begin
            if (irq == 1'b0) act++;
            step();
        end
        check("R10 pulse width", 8'(act), 8'(PULSE));
        check("R10 flag kept", flags, 8'h02);
        check("R10 pin idle after pulse", {7'd0, irq}, 8'h01);
        rd_flags();
    endtask

    task automatic t_polarity();
        wr(3'd4, 8'h0A);
        check("R11 high idle", {7'd0, irq}, 8'h00);
        wdog = 1'b1; step(); wdog = 1'b0;
        check("R11 high active", {7'd0, irq}, 8'h01);
        rd_flags();
        check("R11 high released", {7'd0, irq}, 8'h00);
    endtask

    task automatic t_alarm_level();
        wr(3'd4, 8'h01);
        set_time(7'h10, 7'h20, 7'h05, 7'h07);
        do_tick();
        check("R8 alarm source drives pin", {7'd0, irq}, 8'h00);
        rd_flags();
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        step();
        t_reset();
        t_match_basic();
        t_mask();
        t_all_masked();
        t_no_tick();
        t_events();
        t_read_race();
        t_disabled();
        t_level();
        t_pulse();
        t_polarity();
        t_alarm_level();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule